// File: doc/BRIEF.md
# Switched-Capacitor Step-Down Ratio and Boost Controller

This block is the digital control for a step-down switched-capacitor converter built from a set of time-interleaved unit cells. Each cell can be configured to one of three conversion ratios: 1:2, 2:3 or 1:1. A voltage request arrives as a target code with a one-cycle strobe. A one-bit comparator result tells the controller whether the converter output is still below the target. Each cell also receives its own clock phase. The controller turns the selected ratio and each cell's phase into that cell's 11 switch enables.

When a request raises the target, the controller moves at once to the 1:1 ratio, which delivers the most charge per cycle. It stays there until the comparator reports that the output has reached the target. It then drops to the most efficient ratio whose ideal output still lies at or above the target. Two threshold codes stand for the ideal 1:2 and 2:3 outputs. A request that lowers the target, or leaves it unchanged, goes straight to the efficient ratio. A programmable cycle limit ends a boost that runs too long and raises an error flag.

Each cell adopts a new ratio only at its own next entry into phase 1. Each cell also drives all of its switches open for one cycle whenever its phase changes, so the two phase patterns never overlap.

Top module: `sc_ratio_ctrl`

## Requirements
- R1: `ratio_out` encodes the selected ratio as 0 = 1:2, 1 = 2:3 and 2 = 1:1; the value 3 never appears. Cell i owns `sw_en[i*11 +: 11]`, and bit k of that group drives switch SW(k+1).
- R2: While a cell is in phase 1 and not in a gap cycle, exactly SW1, SW2, SW7 and SW10 are closed (group value 0x243), whatever the ratio.
- R3: While a cell is in phase 2 and not in a gap cycle, SW3 is closed together with a ratio-specific set: SW5, SW8 and SW11 for 1:2 (0x494); SW6 and SW11 for 2:3 (0x424); SW4, SW8 and SW9 for 1:1 (0x18C). All other switches are open.
- R4: A strobed request whose code is greater than the currently held target makes `ratio_out` = 2 and `boost_active` = 1 in the next cycle, and clears `boost_timeout`.
- R5: During boost, a cycle in which `below_target` = 0 and no request is strobed ends the boost in the next cycle. `ratio_out` then becomes the efficient ratio for the held target.
- R6: A strobed request whose code is less than or equal to the held target never enters boost. In the next cycle `ratio_out` is the efficient ratio for the new code, `boost_active` is 0 and `boost_timeout` is 0.
- R7: The efficient ratio for a code c is 1:2 when c ≤ `thr_half`, otherwise 2:3 when c ≤ `thr_two3`, otherwise 1:1.
- R8: If the comparator keeps reporting below target, boost lasts exactly `boost_limit` cycles (for a limit of at least 1). It then ends at the efficient ratio and sets `boost_timeout`, which stays set until the next request.
- R9: A cell applies a ratio change only in the cycle where its phase input goes from 0 to 1. Until then it keeps its previous pattern.
- R10: In the cycle after a cell's phase input changes, all 11 of that cell's switches are open.
- R11: During and after reset: `ratio_out` = 0, `boost_active` = 0 and `boost_timeout` = 0, and the held target is 0. Every cell keeps all switches open until its first phase-1 entry.
- R12: `phase_clk[i]` = 1 means cell i is in phase 1, and 0 means phase 2. Switch outputs follow that phase one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle strobe for a new target code |
| req_code | input | CODE_W | Requested output level code |
| below_target | input | 1 | Comparator result: 1 while the output is under the target |
| thr_half | input | CODE_W | Highest code served by the 1:2 ratio |
| thr_two3 | input | CODE_W | Highest code served by the 2:3 ratio |
| boost_limit | input | TMO_W | Maximum number of boost cycles |
| phase_clk | input | N_MOD | Per-cell phase, 1 = phase 1 |
| sw_en | output | N_MOD*11 | Switch enables, 11 per cell |
| ratio_out | output | 2 | Selected ratio code |
| boost_active | output | 1 | 1 while the forced 1:1 boost is held |
| boost_timeout | output | 1 | Sticky flag set when a boost hits its cycle limit |

## Verification
The bench aims at the following corner cases, each paired with the failure a faulty design would show:
- Raise request: if the raise-versus-lower comparison is reversed or off by one, an equal-code request would wrongly enter boost, or a raise would skip the fast-charge ratio.
- Boost exit: if the exit picks the wrong threshold, the converter would settle in an inefficient or undersized ratio.
- Boost timeout: a counter that is off by one would leave boost one cycle early or late and show up in the exact boost length.
- Phase handling: the reference model follows each cell's phase boundaries. A design that applies a ratio in the middle of a phase, or that omits the all-open gap, would mismatch on the affected cell's switch group in that exact cycle.

// File: rtl/sc_ctrl_pkg.sv
package sc_ctrl_pkg;

   localparam int SW_N = 11;

   typedef enum logic [1:0] {
      RAT_HALF = 2'd0,
      RAT_TWO3 = 2'd1,
      RAT_ONE  = 2'd2
   } ratio_e;

   // phase-1 set: SW1, SW2, SW7, SW10
   localparam logic [SW_N-1:0] PH1_SET = 11'h243;
   // phase-2 sets per ratio, all include SW3
   localparam logic [SW_N-1:0] PH2_HALF = 11'h494;
   localparam logic [SW_N-1:0] PH2_TWO3 = 11'h424;
   localparam logic [SW_N-1:0] PH2_ONE  = 11'h18C;

   function automatic logic [SW_N-1:0] sw_pattern(input ratio_e r, input logic ph1);
      logic [SW_N-1:0] v;
      if (ph1) begin
         v = PH1_SET;
      end else begin
         unique case (r)
            RAT_HALF: v = PH2_HALF;
            RAT_TWO3: v = PH2_TWO3;
            RAT_ONE:  v = PH2_ONE;
            default:  v = '0;
         endcase
      end
      return v;
   endfunction

endpackage

// File: rtl/sc_ratio_pick.sv
module sc_ratio_pick
   import sc_ctrl_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic [CODE_W-1:0] code,
   input  logic [CODE_W-1:0] thr_lo,
   input  logic [CODE_W-1:0] thr_hi,
   output ratio_e            pick
);

   initial assert (CODE_W >= 2) else $error("sc_ratio_pick: CODE_W too small");

   always_comb begin
      if (code <= thr_lo)      pick = RAT_HALF;
      else if (code <= thr_hi) pick = RAT_TWO3;
      else                     pick = RAT_ONE;
   end

endmodule

// File: rtl/sc_boost_seq.sv
module sc_boost_seq
   import sc_ctrl_pkg::*;
#(
   parameter int CODE_W = 8,
   parameter int TMO_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CODE_W-1:0] req_code,
   input  logic              below_target,
   input  logic [CODE_W-1:0] thr_lo,
   input  logic [CODE_W-1:0] thr_hi,
   input  logic [TMO_W-1:0]  boost_limit,
   output ratio_e            ratio_o,
   output logic              boost_o,
   output logic              err_o
);

   initial assert (TMO_W >= 1 && TMO_W <= 31) else $error("sc_boost_seq: TMO_W out of range");

   logic [CODE_W-1:0] code_q;
   logic [TMO_W-1:0]  cnt_q;
   logic              boost_q;
   logic              err_q;
   ratio_e            ratio_q;
   ratio_e            pick_new;
   ratio_e            pick_held;
   logic              raise;
   logic              limit_hit;

   sc_ratio_pick #(.CODE_W(CODE_W)) u_pick_new (
      .code(req_code), .thr_lo(thr_lo), .thr_hi(thr_hi), .pick(pick_new));

   sc_ratio_pick #(.CODE_W(CODE_W)) u_pick_held (
      .code(code_q), .thr_lo(thr_lo), .thr_hi(thr_hi), .pick(pick_held));

   assign raise     = req_code > code_q;
   assign limit_hit = ({1'b0, cnt_q} + {{TMO_W{1'b0}}, 1'b1}) >= {1'b0, boost_limit};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q  <= '0;
         cnt_q   <= '0;
         boost_q <= 1'b0;
         err_q   <= 1'b0;
         ratio_q <= RAT_HALF;
      end else if (req_valid) begin
         code_q <= req_code;
         cnt_q  <= '0;
         err_q  <= 1'b0;
         if (raise) begin
            boost_q <= 1'b1;
            ratio_q <= RAT_ONE;
         end else begin
            boost_q <= 1'b0;
            ratio_q <= pick_new;
         end
      end else if (boost_q) begin
         if (!below_target) begin
            boost_q <= 1'b0;
            ratio_q <= pick_held;
         end else if (limit_hit) begin
            boost_q <= 1'b0;
            err_q   <= 1'b1;
            ratio_q <= pick_held;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign ratio_o = ratio_q;
   assign boost_o = boost_q;
   assign err_o   = err_q;

   p_raise_boost_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_code > code_q) |=> (boost_q && ratio_q == RAT_ONE && !err_q));

   p_lower_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_code <= code_q) |=> (!boost_q && !err_q));

   p_reach_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (boost_q && !req_valid && !below_target) |=> !boost_q);

   p_err_from_boost_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> ($past(boost_q) && $past(below_target) && !$past(req_valid)));

   p_ratio_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_q != 2'd3);

endmodule

// File: rtl/sc_unit_drive.sv
module sc_unit_drive
   import sc_ctrl_pkg::*;
#(
   parameter bit SYNC_PHASE = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            phase_in,
   input  ratio_e          ratio_in,
   output logic [SW_N-1:0] sw_o
);

   logic            ph_s;
   logic            ph_q;
   logic            armed_q;
   ratio_e          arat_q;
   logic [SW_N-1:0] sw_q;
   logic            ph_edge;

   generate
      if (SYNC_PHASE) begin : g_sync
         logic ph_r;
         always_ff @(posedge clk) begin
            if (!rst_n) ph_r <= 1'b0;
            else        ph_r <= phase_in;
         end
         assign ph_s = ph_r;
      end else begin : g_direct
         assign ph_s = phase_in;
      end
   endgenerate

   assign ph_edge = ph_s ^ ph_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q    <= 1'b0;
         armed_q <= 1'b0;
         arat_q  <= RAT_HALF;
         sw_q    <= '0;
      end else begin
         ph_q <= ph_s;
         if (ph_edge && ph_s) begin
            arat_q  <= ratio_in;
            armed_q <= 1'b1;
         end
         if (ph_edge || !armed_q) sw_q <= '0;
         else                     sw_q <= sw_pattern(arat_q, ph_s);
      end
   end

   assign sw_o = sw_q;

   p_gap_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ph_edge |=> (sw_q == '0));

   p_ratio_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(ph_edge && ph_s) |=> $stable(arat_q));

   p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !((|(sw_q & PH1_SET)) && (|(sw_q & ~PH1_SET))));

   p_unarmed_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |-> (sw_q == '0));

endmodule

// File: rtl/sc_ratio_ctrl.sv
module sc_ratio_ctrl
   import sc_ctrl_pkg::*;
#(
   parameter int N_MOD      = 32,
   parameter int CODE_W     = 8,
   parameter int TMO_W      = 16,
   parameter bit SYNC_PHASE = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [CODE_W-1:0]     req_code,
   input  logic                  below_target,
   input  logic [CODE_W-1:0]     thr_half,
   input  logic [CODE_W-1:0]     thr_two3,
   input  logic [TMO_W-1:0]      boost_limit,
   input  logic [N_MOD-1:0]      phase_clk,
   output logic [N_MOD*SW_N-1:0] sw_en,
   output logic [1:0]            ratio_out,
   output logic                  boost_active,
   output logic                  boost_timeout
);

   localparam int SW_TOTAL = N_MOD * SW_N;

   initial assert (N_MOD >= 1 && N_MOD <= 256) else $error("sc_ratio_ctrl: N_MOD out of range");
   initial assert (SW_TOTAL == $bits(sw_en)) else $error("sc_ratio_ctrl: switch bus width");

   ratio_e ratio_w;

   sc_boost_seq #(.CODE_W(CODE_W), .TMO_W(TMO_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
      .below_target(below_target), .thr_lo(thr_half), .thr_hi(thr_two3),
      .boost_limit(boost_limit), .ratio_o(ratio_w), .boost_o(boost_active),
      .err_o(boost_timeout));

   assign ratio_out = ratio_w;

   generate
      for (genvar i = 0; i < N_MOD; i++) begin : g_cell
         sc_unit_drive #(.SYNC_PHASE(SYNC_PHASE)) u_cell (
            .clk(clk), .rst_n(rst_n), .phase_in(phase_clk[i]),
            .ratio_in(ratio_w), .sw_o(sw_en[i*SW_N +: SW_N]));
      end
   endgenerate

   p_reset_state_r11: assert property (@(posedge clk)
      !rst_n |=> (ratio_out == 2'd0 && !boost_active && !boost_timeout && sw_en == '0));

endmodule

// File: tb/tb_sc_ratio_ctrl.sv
module tb_sc_ratio_ctrl;
   localparam int N = 32;
   localparam int CW = 8;
   localparam int TW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [CW-1:0] req_code = '0;
   logic below_target = 1'b1;
   logic [CW-1:0] thr_half = 8'd80;
   logic [CW-1:0] thr_two3 = 8'd120;
   logic [TW-1:0] boost_limit = 16'd60;
   logic [N-1:0] phase_clk = '0;
   logic [N*11-1:0] sw_en;
   logic [1:0] ratio_out;
   logic boost_active, boost_timeout;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int half = 4;
   bit done = 0;

   always #5 clk = ~clk;

   sc_ratio_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
      .below_target(below_target), .thr_half(thr_half), .thr_two3(thr_two3),
      .boost_limit(boost_limit), .phase_clk(phase_clk), .sw_en(sw_en),
      .ratio_out(ratio_out), .boost_active(boost_active),
      .boost_timeout(boost_timeout));

   // reference model state
   int m_code, m_ratio, m_cnt;
   bit m_boost, m_err;
   bit m_ph[N];
   bit m_arm[N];
   int m_arat[N];
   logic [10:0] m_sw[N];

   function automatic logic [10:0] ref_pat(int r, bit p1);
      if (p1) return 11'h243;
      if (r == 0) return 11'h494;
      if (r == 1) return 11'h424;
      return 11'h18C;
   endfunction

   function automatic int ref_eff(int c);
      if (c <= int'(thr_half)) return 0;
      if (c <= int'(thr_two3)) return 1;
      return 2;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_code = 0; m_ratio = 0; m_cnt = 0; m_boost = 0; m_err = 0;
         for (int i = 0; i < N; i++) begin
            m_ph[i] = 0; m_arm[i] = 0; m_arat[i] = 0; m_sw[i] = '0;
         end
      end else begin
         for (int i = 0; i < N; i++) begin
            bit ch;
            ch = (phase_clk[i] != m_ph[i]);
            if (ch || !m_arm[i]) m_sw[i] = '0;
            else m_sw[i] = ref_pat(m_arat[i], phase_clk[i]);
            if (ch && phase_clk[i]) begin
               m_arat[i] = m_ratio; m_arm[i] = 1;
            end
            m_ph[i] = phase_clk[i];
         end
         if (req_valid) begin
            m_err = 0; m_cnt = 0;
            if (int'(req_code) > m_code) begin
               m_boost = 1; m_ratio = 2;
            end else begin
               m_boost = 0; m_ratio = ref_eff(int'(req_code));
            end
            m_code = int'(req_code);
         end else if (m_boost) begin
            if (!below_target) begin
               m_boost = 0; m_ratio = ref_eff(m_code);
            end else if (m_cnt + 1 >= int'(boost_limit)) begin
               m_boost = 0; m_err = 1; m_ratio = ref_eff(m_code);
            end else begin
               m_cnt++;
            end
         end
      end
   end

   task automatic chk(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // phase generator and per-cycle comparison
   always @(negedge clk) begin
      cyc++;
      for (int i = 0; i < N; i++) phase_clk[i] <= ((cyc + i) % (2 * half)) < half;
      if (rst_n) begin
         chk(ratio_out == m_ratio[1:0], "R1 R7 ratio_out", ratio_out, m_ratio);
         chk(boost_active == m_boost, "R4 R5 R6 boost_active", boost_active, m_boost);
         chk(boost_timeout == m_err, "R8 boost_timeout", boost_timeout, m_err);
         for (int i = 0; i < N; i++)
            chk(sw_en[i*11 +: 11] == m_sw[i], $sformatf("R2 R3 R9 R10 R12 cell %0d", i),
                sw_en[i*11 +: 11], m_sw[i]);
      end
   end

   task automatic request(int code);
      @(negedge clk);
      req_valid = 1'b1; req_code = code[CW-1:0];
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic scan_pat(logic [10:0] p2, string tag);
      bit s1 = 0, s2 = 0;
      repeat (24) begin
         @(negedge clk);
         #1;
         if (sw_en[10:0] == 11'h243) s1 = 1;
         if (sw_en[10:0] == p2) s2 = 1;
      end
      chk(s1, {tag, " phase-1 set 0x243 seen"}, s1, 1);
      chk(s2, {tag, " phase-2 set seen"}, s2, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int bc;
      repeat (3) @(negedge clk);
      #1;
      chk(sw_en == '0, "R11 switches open in reset", 0, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(ratio_out == 2'd0 && !boost_active && !boost_timeout, "R11 reset state",
          {ratio_out, boost_active, boost_timeout}, 0);
      scan_pat(11'h494, "R3 ratio 1:2");

      // raise -> boost, then reach target
      below_target = 1'b1;
      request(60);
      #1;
      chk(ratio_out == 2'd2 && boost_active, "R4 raise enters 1:1", ratio_out, 2);
      scan_pat(11'h18C, "R3 ratio 1:1");
      @(negedge clk); below_target = 1'b0;
      @(negedge clk); #1;
      chk(!boost_active && ratio_out == 2'd0, "R5 exit to 1:2 for code 60", ratio_out, 0);
      below_target = 1'b1;

      // raise to 2:3 band with output already there
      request(100);
      below_target = 1'b0;
      @(negedge clk); #1;
      chk(!boost_active && ratio_out == 2'd1, "R5 R7 exit to 2:3 for code 100", ratio_out, 1);
      scan_pat(11'h424, "R3 ratio 2:3");

      // lowering and equal requests
      below_target = 1'b1;
      request(90); #1;
      chk(!boost_active && ratio_out == 2'd1, "R6 lower to 90 stays 2:3", ratio_out, 1);
      request(50); #1;
      chk(!boost_active && ratio_out == 2'd0, "R6 R7 lower to 50 -> 1:2", ratio_out, 0);
      request(50); #1;
      chk(!boost_active, "R6 equal code no boost", boost_active, 0);
      request(80); #1;
      chk(boost_active, "R4 raise to threshold code boosts", boost_active, 1);
      below_target = 1'b0;
      @(negedge clk); #1;
      chk(ratio_out == 2'd0, "R7 code equal to thr_half -> 1:2", ratio_out, 0);

      // timeout
      below_target = 1'b1;
      boost_limit = 16'd20;
      @(negedge clk);
      req_valid = 1'b1; req_code = 8'd200;
      bc = 0;
      repeat (40) begin
         @(negedge clk);
         req_valid = 1'b0;
         #1;
         if (boost_active) bc++;
      end
      chk(bc == 20, "R8 boost length equals limit", bc, 20);
      chk(boost_timeout && ratio_out == 2'd2, "R8 timeout flag, ratio 1:1 for code 200",
          {boost_timeout, ratio_out}, 3'b110);
      request(30); #1;
      chk(!boost_timeout && ratio_out == 2'd0, "R8 request clears flag", boost_timeout, 0);

      // randomized traffic, slower phases
      half = 6;
      boost_limit = 16'd12;
      repeat (3000) begin
         @(negedge clk);
         req_valid = ($urandom_range(0, 9) == 0);
         req_code = CW'($urandom_range(0, 255));
         below_target = ($urandom_range(0, 9) < 8);
         if ($urandom_range(0, 199) == 0) begin
            thr_half = CW'($urandom_range(20, 120));
            thr_two3 = CW'($urandom_range(121, 230));
         end
      end
      @(negedge clk);
      req_valid = 1'b0;
      repeat (5) @(negedge clk);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule